// File: doc/BRIEF.md
# Zero-Address Stack Evaluation Unit

This block evaluates expressions in the style of a stack machine. Arithmetic and logic commands carry no operand addresses. Each one takes its two sources from the two most recent stack entries. It removes both and leaves the single result as the new top. Values enter through a push command that carries a data word. A pop command removes the top entry and returns it on an output port with a one-cycle valid strobe. Computing c = a + b is the four-command stream push a, push b, add, pop.

The stack is a bank of registers addressed by a pointer that moves downward from an empty position one above the highest entry index. A push first steps the pointer to the next free slot and then writes there. A pop first reads the top slot and then steps the pointer back. A controller state machine tracks how full the stack is, using four named states: ST_EMPTY (no entries), ST_SINGLE (one entry), ST_PARTIAL (two up to DEPTH-1 entries) and ST_FULL (DEPTH entries). After every accepted command the next state is derived from the new pointer. This moves the machine one state up on a push, one state down on a pop or a binary operation, or leaves it where it was. Commands that the current state cannot serve raise an error pulse and leave the stack as it was: a push in ST_FULL, a pop in ST_EMPTY, and a binary operation in ST_EMPTY or ST_SINGLE.

Top module: `zstack_alu`

## Requirements
- R1: After reset the stack is empty, pop_valid, overflow and underflow are low, and cmd_ready is high from the first clock edge after reset is released.
- R2: Popped values come out in last-in first-out order; pop_data and a one-cycle pop_valid appear in the cycle after the pop command is accepted.
- R3: A push accepted while DEPTH entries are held raises overflow for one cycle and is discarded, so the top entry is unchanged.
- R4: A pop accepted on an empty stack raises underflow for one cycle and does not raise pop_valid.
- R5: A binary operation accepted with fewer than two entries raises underflow for one cycle and leaves the stack contents and depth unchanged.
- R6: ADD (cmd_op 2) replaces the top two entries with their sum modulo 2^W.
- R7: SUB (cmd_op 3) replaces the top two entries with (second entry minus top entry) modulo 2^W.
- R8: AND (cmd_op 4) and OR (cmd_op 5) replace the top two entries with their bitwise conjunction or disjunction.
- R9: PUSH is cmd_op 0 and POP is cmd_op 1; codes 6 and 7 are accepted with no effect, and nothing happens while cmd_valid is low.
- R10: One command is accepted on every cycle in which cmd_valid is high, so push a, push b, add, pop can be issued on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_op | input | 3 | Command code |
| cmd_data | input | W | Value carried by a push |
| pop_valid | output | 1 | One-cycle strobe for popped data |
| pop_data | output | W | Value removed by the last pop |
| overflow | output | 1 | One-cycle pulse: push onto a full stack |
| underflow | output | 1 | One-cycle pulse: too few entries for the command |

## Verification
The hardest case to reach from the ports is the ST_FULL state. Reaching it needs exactly DEPTH pushes with no intervening pop. A further push must then be refused, and the refusal must leave the old top intact. The stimulus fills the stack with distinct values and pushes once more. It then drains the stack completely, so that each value is checked in reverse order and the refused value never appears. The drain ends with one extra pop, which returns the machine to the underflow case for an empty stack.

// File: rtl/zstack_pkg.sv
package zstack_pkg;

    typedef enum logic [2:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_NOP6 = 3'd6,
        OP_NOP7 = 3'd7
    } zs_op_t;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_SINGLE  = 2'd1,
        ST_PARTIAL = 2'd2,
        ST_FULL    = 2'd3
    } zs_state_t;

    function automatic logic is_binop(input zs_op_t op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) || (op == OP_OR);
    endfunction

endpackage

// File: rtl/zstack_regfile.sv
module zstack_regfile #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_idx_top,
    input  logic [IW-1:0] rd_idx_next,
    output logic [W-1:0]  rd_top,
    output logic [W-1:0]  rd_next
);
    logic [W-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IW'(i))) begin
                slot_q[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_top  = '0;
        rd_next = '0;
        if (int'(rd_idx_top) < DEPTH)  rd_top  = slot_q[rd_idx_top];
        if (int'(rd_idx_next) < DEPTH) rd_next = slot_q[rd_idx_next];
    end
endmodule

// File: rtl/zstack_exec.sv
module zstack_exec
    import zstack_pkg::*;
#(
    parameter int W = 16
) (
    input  zs_op_t       op,
    input  logic [W-1:0] top_val,
    input  logic [W-1:0] next_val,
    output logic [W-1:0] result
);
    always_comb begin
        unique case (op)
            OP_ADD:  result = next_val + top_val;
            OP_SUB:  result = next_val - top_val;
            OP_AND:  result = next_val & top_val;
            OP_OR:   result = next_val | top_val;
            default: result = top_val;
        endcase
    end
endmodule

// File: rtl/zstack_ctrl.sv
module zstack_ctrl
    import zstack_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  zs_op_t        cmd_op,
    output logic          cmd_ready,
    output logic          wr_en,
    output logic          wr_from_exec,
    output logic [IW-1:0] wr_idx,
    output logic [IW-1:0] top_idx,
    output logic [IW-1:0] next_idx,
    output logic          pop_fire,
    output logic          pop_valid,
    output logic          overflow,
    output logic          underflow
);
    localparam logic [PW-1:0] SP_EMPTY = PW'(DEPTH);

    zs_state_t     state_q, state_n;
    logic [PW-1:0] sp_q, sp_n;
    logic          ready_q, acc;
    logic          ovf_n, unf_n;

    assign cmd_ready = ready_q;
    assign acc       = cmd_valid && ready_q;
    assign top_idx   = IW'(sp_q);
    assign next_idx  = (sp_q < SP_EMPTY - PW'(1)) ? IW'(sp_q + PW'(1)) : '0;

    function automatic zs_state_t fill_state(input logic [PW-1:0] sp);
        if (sp == SP_EMPTY)                return ST_EMPTY;
        else if (sp == SP_EMPTY - PW'(1))  return ST_SINGLE;
        else if (sp == '0)                 return ST_FULL;
        else                               return ST_PARTIAL;
    endfunction

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_EMPTY;
            sp_q      <= SP_EMPTY;
            ready_q   <= 1'b0;
            pop_valid <= 1'b0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            state_q   <= state_n;
            sp_q      <= sp_n;
            ready_q   <= 1'b1;
            pop_valid <= pop_fire;
            overflow  <= ovf_n;
            underflow <= unf_n;
        end
    end

    // Action and next-state process
    always_comb begin
        sp_n         = sp_q;
        wr_en        = 1'b0;
        wr_from_exec = 1'b0;
        wr_idx       = IW'(sp_q - PW'(1));
        pop_fire     = 1'b0;
        ovf_n        = 1'b0;
        unf_n        = 1'b0;
        if (acc) begin
            unique case (state_q)
                ST_EMPTY: begin
                    if (cmd_op == OP_PUSH) begin
                        sp_n  = sp_q - PW'(1);
                        wr_en = 1'b1;
                    end else if (cmd_op == OP_POP || is_binop(cmd_op)) begin
                        unf_n = 1'b1;
                    end
                end
                ST_SINGLE: begin
                    if (cmd_op == OP_PUSH) begin
                        sp_n  = sp_q - PW'(1);
                        wr_en = 1'b1;
                    end else if (cmd_op == OP_POP) begin
                        pop_fire = 1'b1;
                        sp_n     = sp_q + PW'(1);
                    end else if (is_binop(cmd_op)) begin
                        unf_n = 1'b1;
                    end
                end
                ST_PARTIAL: begin
                    if (cmd_op == OP_PUSH) begin
                        sp_n  = sp_q - PW'(1);
                        wr_en = 1'b1;
                    end else if (cmd_op == OP_POP) begin
                        pop_fire = 1'b1;
                        sp_n     = sp_q + PW'(1);
                    end else if (is_binop(cmd_op)) begin
                        wr_en        = 1'b1;
                        wr_from_exec = 1'b1;
                        wr_idx       = IW'(sp_q + PW'(1));
                        sp_n         = sp_q + PW'(1);
                    end
                end
                ST_FULL: begin
                    if (cmd_op == OP_PUSH) begin
                        ovf_n = 1'b1;
                    end else if (cmd_op == OP_POP) begin
                        pop_fire = 1'b1;
                        sp_n     = sp_q + PW'(1);
                    end else if (is_binop(cmd_op)) begin
                        wr_en        = 1'b1;
                        wr_from_exec = 1'b1;
                        wr_idx       = IW'(sp_q + PW'(1));
                        sp_n         = sp_q + PW'(1);
                    end
                end
                default: ;
            endcase
        end
        state_n = fill_state(sp_n);
    end

    // Pointer never leaves the legal range (R2)
    assert_sp_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sp_q <= SP_EMPTY);

    // Overflow only after a push met the full state
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> ($past(state_q) == ST_FULL));

    // A refused push leaves the pointer where it was
    assert_push_discard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && state_q == ST_FULL && cmd_op == OP_PUSH) |=> $stable(sp_q));

    // Pop on empty gives no data strobe
    assert_no_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && state_q == ST_EMPTY && cmd_op == OP_POP) |=> (underflow && !pop_valid));

    // Short-stack binary operation leaves the pointer unchanged
    assert_binop_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_binop(cmd_op) && (state_q == ST_EMPTY || state_q == ST_SINGLE))
        |=> (underflow && $stable(sp_q)));

    // Flags are exclusive with each other and with pop data
    assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({overflow, underflow, pop_valid}) <= 1);
endmodule

// File: rtl/zstack_alu.sv
module zstack_alu
    import zstack_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    output logic         cmd_ready,
    input  logic [2:0]   cmd_op,
    input  logic [W-1:0] cmd_data,
    output logic         pop_valid,
    output logic [W-1:0] pop_data,
    output logic         overflow,
    output logic         underflow
);
    localparam int IW = $clog2(DEPTH);

    zs_op_t        op;
    logic          wr_en, wr_from_exec, pop_fire;
    logic [IW-1:0] wr_idx, top_idx, next_idx;
    logic [W-1:0]  rd_top, rd_next, exec_res, wr_data;
    logic [W-1:0]  pop_q;

    assign op       = zs_op_t'(cmd_op);
    assign wr_data  = wr_from_exec ? exec_res : cmd_data;
    assign pop_data = pop_q;

    zstack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (op),
        .cmd_ready    (cmd_ready),
        .wr_en        (wr_en),
        .wr_from_exec (wr_from_exec),
        .wr_idx       (wr_idx),
        .top_idx      (top_idx),
        .next_idx     (next_idx),
        .pop_fire     (pop_fire),
        .pop_valid    (pop_valid),
        .overflow     (overflow),
        .underflow    (underflow)
    );

    zstack_regfile #(.W(W), .DEPTH(DEPTH)) u_rf (
        .clk         (clk),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .rd_idx_top  (top_idx),
        .rd_idx_next (next_idx),
        .rd_top      (rd_top),
        .rd_next     (rd_next)
    );

    zstack_exec #(.W(W)) u_exec (
        .op       (op),
        .top_val  (rd_top),
        .next_val (rd_next),
        .result   (exec_res)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        pop_q <= '0;
        else if (pop_fire) pop_q <= rd_top;
    end

    // Popped data is held until the next pop (R2)
    assert_pop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pop_fire) |-> $stable(pop_q));
endmodule

// File: tb/tb_zstack_alu.sv
module tb_zstack_alu;
    localparam int W     = 16;
    localparam int DEPTH = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [2:0]   cmd_op = 3'd0;
    logic [W-1:0] cmd_data = '0;
    logic         pop_valid, overflow, underflow;
    logic [W-1:0] pop_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    zstack_alu #(.W(W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .pop_valid(pop_valid),
        .pop_data(pop_data), .overflow(overflow), .underflow(underflow)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one command; returns outputs sampled one cycle after acceptance
    task automatic issue(input logic [2:0] op, input logic [W-1:0] d,
                         output logic pv, output logic [W-1:0] pd,
                         output logic ov, output logic un);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        pv = pop_valid; pd = pop_data; ov = overflow; un = underflow;
    endtask

    task automatic push(input logic [W-1:0] d, input string req);
        logic pv, ov, un; logic [W-1:0] pd;
        issue(3'd0, d, pv, pd, ov, un);
        check(req, {pv, ov, un}, 3'b000);
    endtask

    task automatic pop_expect(input logic [W-1:0] exp, input string req);
        logic pv, ov, un; logic [W-1:0] pd;
        issue(3'd1, '0, pv, pd, ov, un);
        check(req, {pv, ov, un}, 3'b100);
        check(req, pd, exp);
    endtask

    task automatic binop_expect(input logic [2:0] op, input logic [W-1:0] a,
                                input logic [W-1:0] b, input logic [W-1:0] exp,
                                input string req);
        logic pv, ov, un; logic [W-1:0] pd;
        push(a, req);
        push(b, req);
        issue(op, '0, pv, pd, ov, un);
        check(req, {pv, ov, un}, 3'b000);
        pop_expect(exp, req);
    endtask

    task automatic t_reset_R1();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 flags in reset", {pop_valid, overflow, underflow}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", cmd_ready, 1'b1);
        check("R1 flags", {pop_valid, overflow, underflow}, 3'b000);
    endtask

    task automatic t_lifo_R2();
        push(16'h1111, "R2 push");
        push(16'h2222, "R2 push");
        push(16'h3333, "R2 push");
        pop_expect(16'h3333, "R2 lifo");
        pop_expect(16'h2222, "R2 lifo");
        pop_expect(16'h1111, "R2 lifo");
    endtask

    task automatic t_full_R3();
        logic pv, ov, un; logic [W-1:0] pd;
        for (int i = 0; i < DEPTH; i++) push(W'(16'h0A00 + i), "R3 fill");
        issue(3'd0, 16'hDEAD, pv, pd, ov, un);
        check("R3 overflow", {pv, ov, un}, 3'b010);
        for (int i = DEPTH - 1; i >= 0; i--) pop_expect(W'(16'h0A00 + i), "R3 drain");
        issue(3'd1, '0, pv, pd, ov, un);
        check("R4 empty after drain", {pv, ov, un}, 3'b001);
    endtask

    task automatic t_pop_empty_R4();
        logic pv, ov, un; logic [W-1:0] pd;
        issue(3'd1, '0, pv, pd, ov, un);
        check("R4 pop empty", {pv, ov, un}, 3'b001);
        @(negedge clk);
        check("R4 pulse one cycle", underflow, 1'b0);
    endtask

    task automatic t_short_binop_R5();
        logic pv, ov, un; logic [W-1:0] pd;
        issue(3'd2, '0, pv, pd, ov, un);
        check("R5 binop empty", {pv, ov, un}, 3'b001);
        push(16'h0042, "R5 push");
        issue(3'd3, '0, pv, pd, ov, un);
        check("R5 binop single", {pv, ov, un}, 3'b001);
        pop_expect(16'h0042, "R5 stack unchanged");
        issue(3'd1, '0, pv, pd, ov, un);
        check("R5 depth unchanged", {pv, ov, un}, 3'b001);
    endtask

    task automatic t_ops();
        binop_expect(3'd2, 16'd5, 16'd7, 16'd12, "R6 add");
        binop_expect(3'd2, 16'hFFFF, 16'h0003, 16'h0002, "R6 add wrap");
        binop_expect(3'd3, 16'd9, 16'd4, 16'd5, "R7 sub order");
        binop_expect(3'd3, 16'd3, 16'd5, 16'hFFFE, "R7 sub wrap");
        binop_expect(3'd4, 16'hF0F0, 16'hFF00, 16'hF000, "R8 and");
        binop_expect(3'd5, 16'hF0F0, 16'h0F00, 16'hFFF0, "R8 or");
    endtask

    task automatic t_nop_R9();
        logic pv, ov, un; logic [W-1:0] pd;
        push(16'h7777, "R9 push");
        issue(3'd6, 16'h1234, pv, pd, ov, un);
        check("R9 code 6", {pv, ov, un}, 3'b000);
        issue(3'd7, 16'h1234, pv, pd, ov, un);
        check("R9 code 7", {pv, ov, un}, 3'b000);
        @(negedge clk);
        cmd_op = 3'd0; cmd_data = 16'h5555;
        repeat (2) @(negedge clk);
        check("R9 valid low", {pop_valid, overflow, underflow}, 3'b000);
        pop_expect(16'h7777, "R9 top untouched");
        issue(3'd1, '0, pv, pd, ov, un);
        check("R9 nothing left", {pv, ov, un}, 3'b001);
    endtask

    task automatic t_stream_R10();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_data = 16'd100;
        @(negedge clk);
        cmd_op = 3'd0; cmd_data = 16'd23;
        @(negedge clk);
        cmd_op = 3'd2;
        @(negedge clk);
        cmd_op = 3'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R10 back-to-back valid", pop_valid, 1'b1);
        check("R10 back-to-back sum", pop_data, 16'd123);
    endtask

    initial begin
        t_reset_R1();
        t_lifo_R2();
        t_full_R3();
        t_pop_empty_R4();
        t_short_binop_R5();
        t_ops();
        t_nop_R9();
        t_stream_R10();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule